// File: doc/BRIEF.md
# Encoded Power-of-Two Output Divider

This block takes a fast source clock and produces two identical differential output pairs at that clock divided by a power of two. A three-bit ratio code picks the ratio, and the code-to-ratio map is not monotonic. The lower half of the code space covers the larger ratios. The upper half starts at a straight divide-by-one pass-through. A bypass select chooses which clock feeds the divider: the VCO-rate clock or a slower reference clock.

The divider is a small state machine with three states. `ST_HOLD` is the reset state. `ST_DIV` toggles a phase flop after each half-period count. `ST_PASS` forwards the source clock to the outputs.

The transitions are:
- `ST_HOLD` to `ST_DIV` or `ST_PASS`: taken on the first source edge after reset is released.
- `ST_DIV` to `ST_DIV` or `ST_PASS`: taken when a low phase ends.
- `ST_PASS` to `ST_PASS` or `ST_DIV`: taken on every source edge.

Each of these transitions re-reads the code. A ratio change therefore only ever begins a new, complete high phase. The active-high master reset clears the counter asynchronously. While it is held, every true output stays low and every complement output stays high.

Top module: `pow2_out_divider`

## Requirements
- R1: Code values 0, 1, 2 and 3 (binary 000, 001, 010, 011) divide the source clock by 2, 4, 8 and 16.
- R2: Code values 4, 5, 6 and 7 (binary 100, 101, 110, 111) divide by 1, 2, 4 and 8. Code 4 passes the source clock through to the outputs.
- R3: For every ratio of two or more, the high time equals ratio/2 source periods, and so does the low time.
- R4: While `mrst` is high, every `out_t` bit is 0 and every `out_c` bit is 1. This takes effect without waiting for a clock edge.
- R5: After `mrst` falls, the first rising source edge raises the true outputs and starts a high phase.
- R6: All true outputs carry the same waveform, and each complement output is the inverse of its true output.
- R7: A code change takes effect only at the rising edge that begins a new period. The high and low phases already under way finish at the old ratio.
- R8: With `use_ref` high the divider counts `clk_ref`. With `use_ref` low it counts `clk_vco`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast VCO-rate source clock |
| clk_ref | input | 1 | Reference clock used in bypass |
| use_ref | input | 1 | 1 selects `clk_ref` as the divider source |
| mrst | input | 1 | Active-high master reset, asynchronous |
| div_code | input | 3 | Ratio code from the configuration register |
| out_t | output | 2 | True outputs, one bit per pair |
| out_c | output | 2 | Complement outputs, one bit per pair |

## Verification
Two events can land in the same source cycle:
- a code write while a period is in progress, and the boundary at which the divider adopts a code;
- a reset and a phase already under way.

The bench writes a divide-by-1 code three cycles into a divide-by-16 high phase. It then times the high phase, the low phase and the following pass-through pulse against 80, 80 and 5 ns. It also raises reset at a point that is not aligned to any clock edge, in the middle of a phase. It checks the output levels 1 ns later, and after release it checks that the first rising edge arrives half a source period later.

// File: rtl/odiv_pkg.sv
`timescale 1ns/1ps
package odiv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_DIV  = 2'd1,
        ST_PASS = 2'd2
    } odiv_state_e;

endpackage

// File: rtl/odiv_code_map.sv
`timescale 1ns/1ps
module odiv_code_map #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              pass_mode,
    output logic [CNT_W-1:0]  half_len
);
    localparam int SEL_W = CODE_W - 1;

    logic [SEL_W:0] lg;

    always_comb begin
        // The upper code half has one less octave than the lower half.
        lg = {1'b0, code[SEL_W-1:0]} + (code[CODE_W-1] ? (SEL_W+1)'(0) : (SEL_W+1)'(1));
        pass_mode = (lg == '0);
        if (lg == '0) begin
            half_len = CNT_W'(1);
        end else begin
            half_len = CNT_W'(1) << (lg - (SEL_W+1)'(1));
        end
    end
endmodule

// File: rtl/odiv_seq.sv
`timescale 1ns/1ps
module odiv_seq
    import odiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             src_clk,
    input  logic             mrst,
    input  logic             map_pass,
    input  logic [CNT_W-1:0] map_half,
    output logic             tog,
    output logic             in_pass,
    output logic [CNT_W-1:0] half_q
);
    odiv_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n, half_n;
    logic             tog_n, adopt;

    always_ff @(posedge src_clk or posedge mrst) begin
        if (mrst) begin
            state  <= ST_HOLD;
            cnt    <= '0;
            tog    <= 1'b0;
            half_q <= CNT_W'(1);
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            tog    <= tog_n;
            half_q <= half_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        tog_n   = tog;
        half_n  = half_q;
        adopt   = 1'b0;
        unique case (state)
            ST_HOLD: adopt = 1'b1;
            ST_DIV: begin
                if (cnt == half_q - CNT_W'(1)) begin
                    if (tog) begin
                        tog_n = 1'b0;
                        cnt_n = '0;
                    end else begin
                        adopt = 1'b1;
                    end
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_PASS: adopt = 1'b1;
            default: state_n = ST_HOLD;
        endcase
        if (adopt) begin
            cnt_n   = '0;
            tog_n   = 1'b1;
            half_n  = map_half;
            state_n = map_pass ? ST_PASS : ST_DIV;
        end
    end

    assign in_pass = (state == ST_PASS);
endmodule

// File: rtl/odiv_out_drive.sv
`timescale 1ns/1ps
module odiv_out_drive #(
    parameter int NPAIRS = 2
) (
    input  logic              src_clk,
    input  logic              mrst,
    input  logic              in_pass,
    input  logic              tog,
    output logic [NPAIRS-1:0] out_t,
    output logic [NPAIRS-1:0] out_c
);
    logic lvl;

    // The mux select only changes just after a rising edge, when both inputs are high.
    assign lvl = mrst ? 1'b0 : (in_pass ? src_clk : tog);

    for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
        assign out_t[i] = lvl;
        assign out_c[i] = ~lvl;
    end
endmodule

// File: rtl/pow2_out_divider.sv
`timescale 1ns/1ps
module pow2_out_divider #(
    parameter int CODE_W = 3,
    parameter int NPAIRS = 2
) (
    input  logic              clk_vco,
    input  logic              clk_ref,
    input  logic              use_ref,
    input  logic              mrst,
    input  logic [CODE_W-1:0] div_code,
    output logic [NPAIRS-1:0] out_t,
    output logic [NPAIRS-1:0] out_c
);
    localparam int CNT_W = 1 << (CODE_W - 1);

    logic             src_clk;
    logic             map_pass, in_pass, tog;
    logic [CNT_W-1:0] map_half, half_q;

    assign src_clk = use_ref ? clk_ref : clk_vco;

    odiv_code_map #(.CODE_W(CODE_W), .CNT_W(CNT_W)) map_i (
        .code(div_code), .pass_mode(map_pass), .half_len(map_half)
    );

    odiv_seq #(.CNT_W(CNT_W)) seq_i (
        .src_clk(src_clk), .mrst(mrst), .map_pass(map_pass), .map_half(map_half),
        .tog(tog), .in_pass(in_pass), .half_q(half_q)
    );

    odiv_out_drive #(.NPAIRS(NPAIRS)) drv_i (
        .src_clk(src_clk), .mrst(mrst), .in_pass(in_pass), .tog(tog),
        .out_t(out_t), .out_c(out_c)
    );
endmodule

// File: rtl/odiv_chk.sv
`timescale 1ns/1ps
module odiv_chk #(
    parameter int NPAIRS = 2,
    parameter int CNT_W  = 4
) (
    input logic              src_clk,
    input logic              mrst,
    input logic [NPAIRS-1:0] out_t,
    input logic [NPAIRS-1:0] out_c,
    input logic              in_pass,
    input logic              tog,
    input logic [CNT_W-1:0]  half
);
    logic [CNT_W:0] run, seen;
    logic           tog_d;

    assign seen = (tog == tog_d) ? run + (CNT_W+1)'(1) : (CNT_W+1)'(1);

    always_ff @(posedge src_clk or posedge mrst) begin
        if (mrst) begin
            run   <= '0;
            tog_d <= 1'b0;
        end else begin
            run   <= in_pass ? '0 : ((seen > (CNT_W+1)'(CNT_W*4)) ? run : seen);
            tog_d <= tog;
        end
    end

    always_comb begin
        if (mrst) begin
            a_r4_reset_levels: assert (out_t == '0 && out_c == '1);
        end
    end

    a_r3_phase_len: assert property (@(posedge src_clk) disable iff (mrst)
        !in_pass |-> seen <= {1'b0, half});

    a_r7_adopt_boundary: assert property (@(posedge src_clk) disable iff (mrst)
        (half != $past(half) || in_pass != $past(in_pass)) |-> ($past(in_pass) || !$past(tog)));

    a_r2_pass_high: assert property (@(posedge src_clk) disable iff (mrst)
        in_pass |-> tog);

    a_r1_half_pow2: assert property (@(posedge src_clk) disable iff (mrst)
        $onehot(half));
endmodule

bind pow2_out_divider odiv_chk #(.NPAIRS(NPAIRS), .CNT_W(CNT_W)) chk_i (
    .src_clk(src_clk), .mrst(mrst), .out_t(out_t), .out_c(out_c),
    .in_pass(in_pass), .tog(tog), .half(half_q)
);

// File: tb/pow2_out_divider_tb.sv
`timescale 1ns/1ps
module pow2_out_divider_tb_top;
    localparam int TVCO = 10;
    localparam int TREF = 14;

    logic       clk_vco = 1'b0;
    logic       clk_ref = 1'b0;
    logic       use_ref = 1'b0;
    logic       mrst    = 1'b1;
    logic [2:0] div_code = 3'd0;
    logic [1:0] out_t, out_c;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    real t0, t1, t2;

    always #(TVCO/2) clk_vco = ~clk_vco;
    always #(TREF/2) clk_ref = ~clk_ref;

    pow2_out_divider dut_i (
        .clk_vco(clk_vco), .clk_ref(clk_ref), .use_ref(use_ref), .mrst(mrst),
        .div_code(div_code), .out_t(out_t), .out_c(out_c)
    );

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] c);
        return c[2] ? (1 << c[1:0]) : (2 << c[1:0]);
    endfunction

    task automatic measure(output real hi, output real per);
        @(posedge out_t[0]); t0 = $realtime;
        @(negedge out_t[0]); t1 = $realtime;
        @(posedge out_t[0]); t2 = $realtime;
        hi  = t1 - t0;
        per = t2 - t0;
    endtask

    task automatic sweep(input bit refsel, input int tsrc);
        real hi, per, eh, ep;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk_vco);
            div_code = 3'(c);
            repeat (40) @(negedge clk_vco);
            measure(hi, per);
            ep = real'(ratio_of(3'(c)) * tsrc);
            eh = ep / 2.0;
            if (refsel) chk(per > ep - 0.01 && per < ep + 0.01, "R8 ref period", per, ep);
            else if (c < 4) chk(per > ep - 0.01 && per < ep + 0.01, "R1 period", per, ep);
            else chk(per > ep - 0.01 && per < ep + 0.01, "R2 period", per, ep);
            chk(hi > eh - 0.01 && hi < eh + 0.01, "R3 high time", hi, eh);
            @(negedge out_t[0]); #1;
            chk(out_t[1] == out_t[0] && out_c == ~out_t, "R6 pairs", real'(out_c), real'(~out_t));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        real ta;
        // R4: held reset with clocks running
        repeat (5) @(negedge clk_vco);
        chk(out_t == 2'b00 && out_c == 2'b11, "R4 reset levels", real'(out_t), 0.0);
        // R5: release at a falling edge; first rise follows half a period later
        @(negedge clk_vco);
        mrst = 1'b0; ta = $realtime;
        @(posedge out_t[0]);
        chk(($realtime - ta) > TVCO/2 - 0.01 && ($realtime - ta) < TVCO/2 + 0.01,
            "R5 first rise", $realtime - ta, real'(TVCO/2));

        sweep(1'b0, TVCO);

        // R7: change /16 to /1 in the middle of a high phase
        @(negedge clk_vco); div_code = 3'd3;
        repeat (40) @(negedge clk_vco);
        @(posedge out_t[0]); t0 = $realtime;
        repeat (3) @(negedge clk_vco);
        div_code = 3'd4;
        @(negedge out_t[0]); t1 = $realtime;
        chk(t1 - t0 > 79.99 && t1 - t0 < 80.01, "R7 old high kept", t1 - t0, 80.0);
        @(posedge out_t[0]); t2 = $realtime;
        chk(t2 - t1 > 79.99 && t2 - t1 < 80.01, "R7 old low kept", t2 - t1, 80.0);
        @(negedge out_t[0]);
        chk($realtime - t2 > 4.99 && $realtime - t2 < 5.01, "R7 new ratio", $realtime - t2, 5.0);

        // R4: asynchronous reset mid-phase
        @(negedge clk_vco); div_code = 3'd3;
        repeat (40) @(negedge clk_vco);
        @(posedge out_t[0]); #23;
        mrst = 1'b1; #1;
        chk(out_t == 2'b00 && out_c == 2'b11, "R4 async reset", real'(out_t), 0.0);
        repeat (20) @(negedge clk_vco);
        chk(out_t == 2'b00 && out_c == 2'b11, "R4 reset hold", real'(out_t), 0.0);

        // R8: bypass source, switched under reset
        use_ref = 1'b1;
        @(negedge clk_ref); mrst = 1'b0;
        sweep(1'b1, TREF);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule